// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. The page size is 1 KiB, and the translation tables live in ordinary memory, so the block walks them itself. The low 10 bits of the virtual address are the byte offset, which passes through untouched. The 22-bit page number splits into two indices. The upper 12 bits select an entry in the outer table. The next 10 bits select an entry in the inner table that the outer entry names. A table-base input gives the byte address of the outer table. A table-length input gives how many outer entries exist, and an outer index at or past that count is refused before any memory traffic happens.

Each request costs two dependent memory reads when the walk succeeds. Every table entry is 32 bits wide. Bit 0 is the valid flag, bits [9:1] are reserved and ignored, and bits [31:10] hold a 22-bit frame number. In an outer entry, that frame number is where the inner table starts (frame << 10). In an inner entry, it is the frame of the target page. Each walk ends with one response carrying either the physical address or a fault code that names the stage that failed. The CPU side uses a valid/ready request and a one-cycle response pulse. The memory side has an address handshake and a separate data-return strobe.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `mem_rd_valid_o` are both 0.
- R2: If the outer index (vaddr[31:20]) is greater than or equal to `ptlen_i`, the response has `rsp_fault_o`=1 and `rsp_code_o`=1, and no memory read is issued.
- R3: The first memory read of a walk is at address `ptbr_i + 4*vaddr[31:20]` (modulo 2^32).
- R4: If bit 0 of the outer entry is 0, the response has `rsp_fault_o`=1 and `rsp_code_o`=2, and exactly one memory read was issued.
- R5: The second memory read is at address `(outer[31:10] << 10) + 4*vaddr[19:10]` (modulo 2^32).
- R6: If bit 0 of the inner entry is 0, the response has `rsp_fault_o`=1 and `rsp_code_o`=3, after exactly two reads.
- R7: On success, `rsp_paddr_o = {inner[31:10], vaddr[9:0]}`, with `rsp_fault_o`=0 and `rsp_code_o`=0. On any fault, `rsp_paddr_o` is 0.
- R8: While `mem_rd_valid_o` is 1 and `mem_rd_ready_i` is 0, the request and its address stay unchanged into the next cycle.
- R9: `req_ready_o` is 0 from the accepting edge until the response. `rsp_valid_o` is high for exactly one cycle per accepted request. When `req_ready_o` is 1, neither a read request nor a response is active.
- R10: Bits [9:1] of any table entry do not affect the read addresses or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_i | input | 32 | Byte address of the outer table |
| ptlen_i | input | 13 | Number of valid outer entries (0..4096) |
| req_valid_i | input | 1 | Translation request present |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle; request taken when valid and ready |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Walk failed |
| rsp_code_o | output | 2 | 0 none, 1 length, 2 outer invalid, 3 inner invalid |
| rsp_paddr_o | output | 32 | Physical address on success, else 0 |
| mem_rd_valid_o | output | 1 | Table read request |
| mem_rd_addr_o | output | 32 | Byte address of the entry to read |
| mem_rd_ready_i | input | 1 | Memory accepts the read request |
| mem_rd_dvalid_i | input | 1 | Read data returned this cycle |
| mem_rd_data_i | input | 32 | Returned table entry |

## Verification
The assertions watch the handshake rules on every cycle. They check that a stalled read keeps its address, that a response lasts one cycle, that an idle walker shows no activity, and that the fault codes match the checks that raised them (the length comparison and the outer valid bit). Only the bench scenarios can show that the addresses and physical results are numerically right. It sweeps outer and inner indices against several length limits and a computed table image whose valid bits and reserved bits vary. It also varies memory latency and stalls, and it counts the reads per walk to confirm that each fault stops the walk early.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned OFF_W     = 10;
  localparam int unsigned IDX1_W    = 12;
  localparam int unsigned IDX2_W    = 10;
  localparam int unsigned PTE_W     = 32;
  localparam int unsigned FRAME_W   = PTE_W - OFF_W;
  localparam int unsigned PA_W      = FRAME_W + OFF_W;
  localparam int unsigned LEN_W     = IDX1_W + 1;
  localparam int unsigned PTE_SHIFT = $clog2(PTE_W / 8);

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LEN   = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK_LEN, S_FETCH_L1, S_WAIT_L1,
    S_FETCH_L2, S_WAIT_L2, S_DONE, S_FAULT
  } walk_st_e;

  function automatic logic [IDX1_W-1:0] va_outer_idx(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IDX1_W];
  endfunction

  function automatic logic [IDX2_W-1:0] va_inner_idx(input logic [VA_W-1:0] va);
    return va[OFF_W +: IDX2_W];
  endfunction

  function automatic logic [OFF_W-1:0] va_offset(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic pte_ok(input logic [PTE_W-1:0] pte);
    return pte[0];
  endfunction

  function automatic logic [FRAME_W-1:0] pte_frame(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1 -: FRAME_W];
  endfunction

  function automatic logic [PA_W-1:0] outer_pte_addr(input logic [PA_W-1:0] base,
                                                     input logic [IDX1_W-1:0] idx);
    return base + (PA_W'(idx) << PTE_SHIFT);
  endfunction

  function automatic logic [PA_W-1:0] inner_pte_addr(input logic [FRAME_W-1:0] frame,
                                                     input logic [IDX2_W-1:0] idx);
    return {frame, {OFF_W{1'b0}}} + (PA_W'(idx) << PTE_SHIFT);
  endfunction

  function automatic logic [PA_W-1:0] make_paddr(input logic [FRAME_W-1:0] frame,
                                                 input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction
endpackage

// File: rtl/pt_len_check.sv
module pt_len_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned IW = IDX1_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic [IW-1:0] idx_i,
  input  logic [LW-1:0] len_i,
  output logic          out_of_range_o
);
  localparam int unsigned EXT = LW - IW;

  always_comb begin
    out_of_range_o = ({{EXT{1'b0}}, idx_i} >= len_i);
  end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walker_pkg::*;
(
  input  logic               inner_sel_i,
  input  logic [PA_W-1:0]    base_i,
  input  logic [IDX1_W-1:0]  outer_idx_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic [IDX2_W-1:0]  inner_idx_i,
  output logic [PA_W-1:0]    addr_o
);
  logic [PA_W-1:0] outer_addr;
  logic [PA_W-1:0] inner_addr;

  always_comb begin
    outer_addr = outer_pte_addr(base_i, outer_idx_i);
    inner_addr = inner_pte_addr(tbl_frame_i, inner_idx_i);
    addr_o     = inner_sel_i ? inner_addr : outer_addr;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid_i,
  input  logic     len_bad_i,
  input  logic     mem_rd_ready_i,
  input  logic     mem_rd_dvalid_i,
  input  logic     pte_ok_i,
  output walk_st_e st_o,
  output logic     accept_o,
  output logic     outer_take_o,
  output logic     inner_take_o,
  output logic     inner_sel_o,
  output logic     req_ready_o,
  output logic     rsp_valid_o,
  output logic     rsp_fault_o,
  output logic [1:0] rsp_code_o,
  output logic     mem_rd_valid_o
);
  walk_st_e st_q, st_d;
  flt_e     code_q, code_d;

  always_comb begin
    st_d         = st_q;
    code_d       = code_q;
    accept_o     = 1'b0;
    outer_take_o = 1'b0;
    inner_take_o = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          st_d     = S_CHECK_LEN;
          code_d   = FLT_NONE;
        end
      end
      S_CHECK_LEN: begin
        if (len_bad_i) begin
          st_d   = S_FAULT;
          code_d = FLT_LEN;
        end else begin
          st_d = S_FETCH_L1;
        end
      end
      S_FETCH_L1: if (mem_rd_ready_i) st_d = S_WAIT_L1;
      S_WAIT_L1: begin
        if (mem_rd_dvalid_i) begin
          if (pte_ok_i) begin
            outer_take_o = 1'b1;
            st_d         = S_FETCH_L2;
          end else begin
            st_d   = S_FAULT;
            code_d = FLT_OUTER;
          end
        end
      end
      S_FETCH_L2: if (mem_rd_ready_i) st_d = S_WAIT_L2;
      S_WAIT_L2: begin
        if (mem_rd_dvalid_i) begin
          if (pte_ok_i) begin
            inner_take_o = 1'b1;
            st_d         = S_DONE;
          end else begin
            st_d   = S_FAULT;
            code_d = FLT_INNER;
          end
        end
      end
      S_DONE:  st_d = S_IDLE;
      S_FAULT: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      code_q <= FLT_NONE;
    end else begin
      st_q   <= st_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    st_o           = st_q;
    req_ready_o    = (st_q == S_IDLE);
    mem_rd_valid_o = (st_q == S_FETCH_L1) || (st_q == S_FETCH_L2);
    inner_sel_o    = (st_q == S_FETCH_L2);
    rsp_valid_o    = (st_q == S_DONE) || (st_q == S_FAULT);
    rsp_fault_o    = (st_q == S_FAULT);
    rsp_code_o     = (st_q == S_FAULT) ? code_q : FLT_NONE;
  end

  // R2: a failed length comparison ends the walk with the length code
  assert_len_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHECK_LEN && len_bad_i) |=> (rsp_valid_o && rsp_code_o == FLT_LEN));

  // R4: an invalid outer entry ends the walk with the outer code
  assert_outer_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT_L1 && mem_rd_dvalid_i && !pte_ok_i)
      |=> (rsp_valid_o && rsp_fault_o && rsp_code_o == FLT_OUTER));

  // R7: the code is nonzero exactly when a fault is reported
  assert_code_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (rsp_fault_o == (rsp_code_o != FLT_NONE)));

  // R9: a response lasts one cycle and is followed by idle
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
endmodule

// File: rtl/pt_walk_regs.sv
module pt_walk_regs
  import pt_walker_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic               outer_take_i,
  input  logic               inner_take_i,
  input  logic [PTE_W-1:0]   pte_i,
  output logic [VA_W-1:0]    va_o,
  output logic [FRAME_W-1:0] tbl_frame_o,
  output logic [PA_W-1:0]    paddr_o
);
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [FRAME_W-1:0] pg_frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q        <= '0;
      tbl_frame_q <= '0;
      pg_frame_q  <= '0;
    end else begin
      if (accept_i)     va_q        <= vaddr_i;
      if (outer_take_i) tbl_frame_q <= pte_frame(pte_i);
      if (inner_take_i) pg_frame_q  <= pte_frame(pte_i);
    end
  end

  always_comb begin
    va_o        = va_q;
    tbl_frame_o = tbl_frame_q;
    paddr_o     = make_paddr(pg_frame_q, va_offset(va_q));
  end

  // R9: the latched address cannot change mid-walk since no new accept occurs
  assert_va_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(va_q));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   ptbr_i,
  input  logic [LEN_W-1:0]  ptlen_i,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [1:0]        rsp_code_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic              mem_rd_valid_o,
  output logic [PA_W-1:0]   mem_rd_addr_o,
  input  logic              mem_rd_ready_i,
  input  logic              mem_rd_dvalid_i,
  input  logic [PTE_W-1:0]  mem_rd_data_i
);
  walk_st_e           st;
  logic               accept, outer_take, inner_take, inner_sel, len_bad;
  logic               fsm_rsp_valid, fsm_rsp_fault;
  logic [VA_W-1:0]    va;
  logic [FRAME_W-1:0] tbl_frame;
  logic [PA_W-1:0]    paddr;

  pt_walk_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .len_bad_i      (len_bad),
    .mem_rd_ready_i (mem_rd_ready_i),
    .mem_rd_dvalid_i(mem_rd_dvalid_i),
    .pte_ok_i       (pte_ok(mem_rd_data_i)),
    .st_o           (st),
    .accept_o       (accept),
    .outer_take_o   (outer_take),
    .inner_take_o   (inner_take),
    .inner_sel_o    (inner_sel),
    .req_ready_o    (req_ready_o),
    .rsp_valid_o    (fsm_rsp_valid),
    .rsp_fault_o    (fsm_rsp_fault),
    .rsp_code_o     (rsp_code_o),
    .mem_rd_valid_o (mem_rd_valid_o)
  );

  pt_walk_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .vaddr_i     (req_vaddr_i),
    .outer_take_i(outer_take),
    .inner_take_i(inner_take),
    .pte_i       (mem_rd_data_i),
    .va_o        (va),
    .tbl_frame_o (tbl_frame),
    .paddr_o     (paddr)
  );

  pt_len_check u_len (
    .idx_i         (va_outer_idx(va)),
    .len_i         (ptlen_i),
    .out_of_range_o(len_bad)
  );

  pt_addr_gen u_addr (
    .inner_sel_i(inner_sel),
    .base_i     (ptbr_i),
    .outer_idx_i(va_outer_idx(va)),
    .tbl_frame_i(tbl_frame),
    .inner_idx_i(va_inner_idx(va)),
    .addr_o     (mem_rd_addr_o)
  );

  always_comb begin
    rsp_valid_o = fsm_rsp_valid;
    rsp_fault_o = fsm_rsp_fault;
    rsp_paddr_o = (fsm_rsp_valid && !fsm_rsp_fault) ? paddr : '0;
  end

  // R8: a stalled read request keeps its address
  assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

  // R9: an idle walker shows no activity on either side
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (!mem_rd_valid_o && !rsp_valid_o));

  // R9: a request is only taken while idle
  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !accept);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TBL_BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptbr;
  logic [12:0] ptlen;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr, mem_addr;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_dvalid = 1'b0;
  logic [31:0] mem_data = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int rd_cnt = 0;
  logic [31:0] rd_log [2];
  bit stall_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .ptbr_i(ptbr), .ptlen_i(ptlen),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_code_o(rsp_code),
    .rsp_paddr_o(rsp_paddr), .mem_rd_valid_o(mem_valid), .mem_rd_addr_o(mem_addr),
    .mem_rd_ready_i(mem_ready), .mem_rd_dvalid_i(mem_dvalid), .mem_rd_data_i(mem_data)
  );

  // Table image computed from the address: outer entry p1 points at a private 4 KiB inner table.
  function automatic logic [21:0] inner_frame_of(int t, int p2);
    return 22'((t * 32'h123 + p2 * 32'h45) ^ 32'h2A5A5);
  endfunction
  function automatic bit outer_valid_of(int p1);
    return (p1 % 7) != 3;
  endfunction
  function automatic bit inner_valid_of(int t, int p2);
    return ((p2 + t) % 5) != 0;
  endfunction

  function automatic logic [31:0] image_at(logic [31:0] a);
    logic [31:0] rel;
    int p1, t, p2;
    rel = a - ptbr;
    if (rel < 32'd16384) begin
      p1 = int'(rel >> 2);
      // R10: reserved bits carry nonzero junk
      return {22'(32'h1000 + 4 * p1), 9'(p1), outer_valid_of(p1)};
    end
    t  = int'(a >> 12) - 32'h400;
    p2 = int'((a >> 2) & 32'h3FF);
    return {inner_frame_of(t, p2), 9'(p2) ^ 9'h1AA, inner_valid_of(t, p2)};
  endfunction

  // Memory responder with variable latency and optional stalls
  int pend = 0;
  int cnt = 0;
  int tick = 0;
  logic [31:0] addr_q = '0;
  always @(posedge clk) begin
    tick       <= tick + 1;
    cycles     <= cycles + 1;
    mem_dvalid <= 1'b0;
    mem_ready  <= stall_mode ? ((tick % 3) != 1) : 1'b1;
    if (pend != 0) begin
      if (cnt == 0) begin
        mem_dvalid <= 1'b1;
        mem_data   <= image_at(addr_q);
        pend       <= 0;
      end else begin
        cnt <= cnt - 1;
      end
    end else if (rst_n && mem_valid && mem_ready) begin
      pend   <= 1;
      cnt    <= int'((mem_addr >> 2) % 3);
      addr_q <= mem_addr;
      if (rd_cnt < 2) rd_log[rd_cnt] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic walk(int p1, int p2, int off);
    logic [31:0] va, exp_a1, exp_a2, exp_pa;
    int exp_code, exp_reads, guard;
    logic [31:0] held;
    bit held_v;
    va = {12'(p1), 10'(p2), 10'(off)};
    exp_a1 = ptbr + 32'(4 * p1);
    exp_a2 = 32'((32'h1000 + 4 * p1) << 10) + 32'(4 * p2);
    exp_pa = {inner_frame_of(p1, p2), 10'(off)};
    if (p1 >= int'(ptlen))              begin exp_code = 1; exp_reads = 0; end
    else if (!outer_valid_of(p1))       begin exp_code = 2; exp_reads = 1; end
    else if (!inner_valid_of(p1, p2))   begin exp_code = 3; exp_reads = 2; end
    else                                begin exp_code = 0; exp_reads = 2; end

    @(negedge clk);
    rd_cnt    = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = 32'hDEAD_BEEF;
    guard = 0;
    held_v = 1'b0;
    held = '0;
    while (!rsp_valid && guard < 200) begin
      chk(!req_ready, "R9", "ready while busy", 32'(req_ready), 32'd0);
      if (held_v) chk(mem_valid && mem_addr == held, "R8", "stalled address", mem_addr, held);
      held_v = mem_valid && !mem_ready;
      held   = mem_addr;
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid, "R9", "response arrived", 32'(rsp_valid), 32'd1);
    chk(rsp_code == 2'(exp_code), exp_code == 1 ? "R2" : exp_code == 2 ? "R4" :
        exp_code == 3 ? "R6" : "R7", "code", 32'(rsp_code), 32'(exp_code));
    chk(rsp_fault == (exp_code != 0), "R7", "fault flag", 32'(rsp_fault), 32'(exp_code != 0));
    chk(rd_cnt == exp_reads, exp_code == 1 ? "R2" : "R4", "read count",
        32'(rd_cnt), 32'(exp_reads));
    if (exp_reads >= 1) chk(rd_log[0] == exp_a1, "R3", "outer entry address", rd_log[0], exp_a1);
    if (exp_reads >= 2) chk(rd_log[1] == exp_a2, "R5", "inner entry address (R10)", rd_log[1], exp_a2);
    chk(rsp_paddr == (exp_code == 0 ? exp_pa : 32'd0), "R7", "physical address (R10)",
        rsp_paddr, exp_code == 0 ? exp_pa : 32'd0);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", "single response then idle",
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    int lens [3] = '{4096, 100, 0};
    int p1s [10] = '{0, 1, 2, 3, 10, 99, 100, 101, 2048, 4095};
    ptbr  = TBL_BASE;
    ptlen = 13'd4096;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_valid, "R1", "reset outputs",
        {29'd0, req_ready, rsp_valid, mem_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_valid, "R1", "idle after reset",
        {29'd0, req_ready, rsp_valid, mem_valid}, 32'd4);
    for (int li = 0; li < 3; li++) begin
      ptlen = 13'(lens[li]);
      stall_mode = (li == 1);
      for (int i = 0; i < 10; i++)
        for (int p2 = 0; p2 < 1024; p2 += 61)
          walk(p1s[i], p2, (p2 * 13 + p1s[i]) & 32'h3FF);
    end
    ptbr = TBL_BASE + 32'h0004_0000;
    ptlen = 13'd4096;
    stall_mode = 1'b1;
    for (int p1 = 0; p1 < 16; p1++) walk(p1, 1023, 1023);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule